// File: doc/BRIEF.md
# Banked Interrupt Controller with Edge Latches

A memory-mapped interrupt controller that gathers 64 raw interrupt inputs and reduces them to two processor lines: a normal interrupt (`irq_o`) and a fast interrupt (`fiq_o`). Sources are grouped into 32-bit banks. Bank 0 holds sources 0 to 31 and bank 1 holds sources 32 to 63, so source n sits in bank n>>5 at bit n&31. For every source, software picks the sensing mode (level or edge), the active polarity, whether both edges count, and which output line it drives. It can also enable the source and raise it by software.

Edge-sensed sources record each event in a sticky latch. The latch holds until software clears it through a dedicated write-one-to-clear register. Enable and soft trigger each have a pair of registers: one sets bits, the other clears them. Software can read three status views: raw pending, pending routed to the normal line, and pending routed to the fast line. These let a handler find the source to service. The register port is a plain single-cycle port with a write strobe, address, write data and combinational read data.

Top module: `banked_intc`

## Requirements
- R1: Byte address bits [7:3] select the register, bit [2] selects the bank (0 = sources 0..31, 1 = sources 32..63), and bits [1:0] are ignored. Source n maps to bank n>>5, bit n&31.
- R2: The enable state uses two addresses. Writing ones at 0x20 enables the matching sources and writing ones at 0x28 disables them. Zero bits leave the state unchanged. Reading 0x20 returns the enable state.
- R3: The soft trigger uses 0x30 for set (readable) and 0x38 for clear. Both act only on bits written as 1. A set soft bit makes the source pending whatever its input, sense or polarity.
- R4: The route register at 0x18 sends a source to the fast line when its bit is 1 and to the normal line when its bit is 0. A source never appears in both routed views.
- R5: The sense register at 0x40 marks a source level-sensed with 1 and edge-sensed with 0. The polarity register at 0x50 makes a level source pending while its input equals the polarity bit (1 = active high, 0 = active low).
- R6: An edge-sensed source with the both-edges bit clear sets its latch on a rising input when its polarity bit is 1, and on a falling input when it is 0. The latch bits read at 0x60, and the latch is visible one clock after the input change.
- R7: When a source's bit in the both-edges register at 0x48 is 1, an edge-sensed source latches on either input transition.
- R8: Writing a 1 at 0x58 clears that source's latch, and the latch otherwise holds. A clear does not change the pending state of a level source. An edge in the same cycle as a clear of that bit leaves the latch set.
- R9: The raw view at 0x10 is the soft bit OR'd with either the level condition (level sources) or the latch (edge sources). The normal view at 0x00 is raw AND enable AND NOT route. The fast view at 0x08 is raw AND enable AND route.
- R10: `irq_o` and `fiq_o` are the OR of all bits of the normal and fast views, registered, so each follows the view one clock later.
- R11: Reset clears enable, soft, route, both-edges and latches, and sets sense and polarity to all ones (level, active high). Both outputs are low during and right after reset.
- R12: Reads of the clear registers (0x28, 0x38, 0x58) and of unmapped indexes (13 and up) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe, acts on the rising clock edge |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational from `addr_i` |
| src_i | input | 64 | Raw interrupt source inputs |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench builds the controller with its default of two banks, giving 64 sources and an 8-bit address. This puts the bank-select bit at address bit 2, so both banks of every register are reached. Directed sequences cover the same-cycle clear-versus-edge race, falling and both-edge capture, and clears on level sources. A long random phase mixes writes to every register with toggling inputs across both banks and compares every read and both output lines against a cycle-level model.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned BANK_W    = 32;
  localparam int unsigned REG_IDX_W = 5;

  // register index = addr[msb:3]; values fixed by the software-visible map
  typedef enum logic [REG_IDX_W-1:0] {
    RI_IRQ_ST  = 5'd0,
    RI_FIQ_ST  = 5'd1,
    RI_RAW_ST  = 5'd2,
    RI_ROUTE   = 5'd3,
    RI_EN_SET  = 5'd4,
    RI_EN_CLR  = 5'd5,
    RI_SW_SET  = 5'd6,
    RI_SW_CLR  = 5'd7,
    RI_SENSE   = 5'd8,
    RI_BOTH    = 5'd9,
    RI_POL     = 5'd10,
    RI_LAT_CLR = 5'd11,
    RI_LAT_ST  = 5'd12
  } reg_idx_e;

  typedef struct packed {
    logic en_set;
    logic en_clr;
    logic sw_set;
    logic sw_clr;
    logic route;
    logic sense;
    logic both;
    logic pol;
    logic lat_clr;
  } bank_wr_t;

  typedef struct packed {
    logic [BANK_W-1:0] irq;
    logic [BANK_W-1:0] fiq;
    logic [BANK_W-1:0] raw;
    logic [BANK_W-1:0] route;
    logic [BANK_W-1:0] en;
    logic [BANK_W-1:0] sw;
    logic [BANK_W-1:0] sense;
    logic [BANK_W-1:0] both;
    logic [BANK_W-1:0] pol;
    logic [BANK_W-1:0] lat;
  } bank_view_t;
endpackage

// File: rtl/intc_regdec.sv
module intc_regdec
  import intc_pkg::*;
#(
  parameter int unsigned NUM_BANKS  = 2,
  parameter int unsigned BANK_SEL_W = 1,
  parameter int unsigned ADDR_W     = 8
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  bank_view_t        views_i [NUM_BANKS],
  output bank_wr_t          wr_o    [NUM_BANKS],
  output logic [BANK_W-1:0] rdata_o
);
  logic [BANK_SEL_W-1:0] bank_idx;
  reg_idx_e              reg_idx;
  bank_view_t            sel_view;
  logic [1:0]            unused_lsb;

  assign bank_idx   = addr_i[2 +: BANK_SEL_W];
  assign reg_idx    = reg_idx_e'(addr_i[2+BANK_SEL_W +: REG_IDX_W]);
  assign sel_view   = views_i[bank_idx];
  assign unused_lsb = addr_i[1:0];

  always_comb begin
    for (int unsigned b = 0; b < NUM_BANKS; b++) begin
      wr_o[b] = '0;
      if (we_i && bank_idx == BANK_SEL_W'(b)) begin
        case (reg_idx)
          RI_EN_SET:  wr_o[b].en_set  = 1'b1;
          RI_EN_CLR:  wr_o[b].en_clr  = 1'b1;
          RI_SW_SET:  wr_o[b].sw_set  = 1'b1;
          RI_SW_CLR:  wr_o[b].sw_clr  = 1'b1;
          RI_ROUTE:   wr_o[b].route   = 1'b1;
          RI_SENSE:   wr_o[b].sense   = 1'b1;
          RI_BOTH:    wr_o[b].both    = 1'b1;
          RI_POL:     wr_o[b].pol     = 1'b1;
          RI_LAT_CLR: wr_o[b].lat_clr = 1'b1;
          default:    ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_idx)
      RI_IRQ_ST: rdata_o = sel_view.irq;
      RI_FIQ_ST: rdata_o = sel_view.fiq;
      RI_RAW_ST: rdata_o = sel_view.raw;
      RI_ROUTE:  rdata_o = sel_view.route;
      RI_EN_SET: rdata_o = sel_view.en;
      RI_SW_SET: rdata_o = sel_view.sw;
      RI_SENSE:  rdata_o = sel_view.sense;
      RI_BOTH:   rdata_o = sel_view.both;
      RI_POL:    rdata_o = sel_view.pol;
      RI_LAT_ST: rdata_o = sel_view.lat;
      default:   rdata_o = '0;  // clear regs and holes read zero
    endcase
  end
endmodule

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] src_i,
  input  bank_wr_t          wr_i,
  input  logic [BANK_W-1:0] wdata_i,
  output bank_view_t        view_o
);
  logic [BANK_W-1:0] en_q, sw_q, route_q, sense_q, both_q, pol_q, lat_q, prev_q;
  logic [BANK_W-1:0] act_now, act_prev, edge_hit, lat_clr, raw;

  assign act_now  = ~(src_i ^ pol_q);
  assign act_prev = ~(prev_q ^ pol_q);
  assign edge_hit = (both_q & (src_i ^ prev_q)) | (~both_q & act_now & ~act_prev);
  assign lat_clr  = wr_i.lat_clr ? wdata_i : '0;
  assign raw      = sw_q | (sense_q & act_now) | (~sense_q & lat_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      sw_q    <= '0;
      route_q <= '0;
      sense_q <= '1;
      both_q  <= '0;
      pol_q   <= '1;
      lat_q   <= '0;
      prev_q  <= '0;
    end else begin
      prev_q <= src_i;
      // a fresh edge outranks a same-cycle clear
      lat_q  <= (lat_q & ~lat_clr) | (edge_hit & ~sense_q);
      if (wr_i.en_set) en_q    <= en_q | wdata_i;
      if (wr_i.en_clr) en_q    <= en_q & ~wdata_i;
      if (wr_i.sw_set) sw_q    <= sw_q | wdata_i;
      if (wr_i.sw_clr) sw_q    <= sw_q & ~wdata_i;
      if (wr_i.route)  route_q <= wdata_i;
      if (wr_i.sense)  sense_q <= wdata_i;
      if (wr_i.both)   both_q  <= wdata_i;
      if (wr_i.pol)    pol_q   <= wdata_i;
    end
  end

  always_comb begin
    view_o.raw   = raw;
    view_o.irq   = raw & en_q & ~route_q;
    view_o.fiq   = raw & en_q & route_q;
    view_o.route = route_q;
    view_o.en    = en_q;
    view_o.sw    = sw_q;
    view_o.sense = sense_q;
    view_o.both  = both_q;
    view_o.pol   = pol_q;
    view_o.lat   = lat_q;
  end
endmodule

// File: rtl/banked_intc.sv
module banked_intc
  import intc_pkg::*;
#(
  parameter  int unsigned NUM_BANKS  = 2,
  localparam int unsigned NUM_SRC    = NUM_BANKS * BANK_W,
  localparam int unsigned BANK_SEL_W = $clog2(NUM_BANKS),
  localparam int unsigned ADDR_W     = 2 + BANK_SEL_W + REG_IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BANK_W-1:0]  wdata_i,
  output logic [BANK_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o,
  output logic               fiq_o
);
  bank_wr_t           bank_wr   [NUM_BANKS];
  bank_view_t         bank_view [NUM_BANKS];
  logic [NUM_SRC-1:0] en_all, lat_all, lat_clr_all, irq_all, fiq_all;

  intc_regdec #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_SEL_W(BANK_SEL_W),
    .ADDR_W    (ADDR_W)
  ) u_regdec (
    .we_i   (we_i),
    .addr_i (addr_i),
    .views_i(bank_view),
    .wr_o   (bank_wr),
    .rdata_o(rdata_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    intc_bank u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (src_i[b*BANK_W +: BANK_W]),
      .wr_i   (bank_wr[b]),
      .wdata_i(wdata_i),
      .view_o (bank_view[b])
    );
    assign en_all[b*BANK_W +: BANK_W]      = bank_view[b].en;
    assign lat_all[b*BANK_W +: BANK_W]     = bank_view[b].lat;
    assign irq_all[b*BANK_W +: BANK_W]     = bank_view[b].irq;
    assign fiq_all[b*BANK_W +: BANK_W]     = bank_view[b].fiq;
    assign lat_clr_all[b*BANK_W +: BANK_W] = bank_wr[b].lat_clr ? wdata_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= |irq_all;
      fiq_o <= |fiq_all;
    end
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 64,
  parameter int unsigned BANK_SEL_W = 1,
  parameter int unsigned ADDR_W     = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [BANK_W-1:0]  wdata_i,
  input logic [BANK_W-1:0]  rdata_o,
  input logic               irq_o,
  input logic               fiq_o,
  input logic [NUM_SRC-1:0] en_all,
  input logic [NUM_SRC-1:0] lat_all,
  input logic [NUM_SRC-1:0] lat_clr_all,
  input logic [NUM_SRC-1:0] irq_all,
  input logic [NUM_SRC-1:0] fiq_all
);
  localparam logic [ADDR_W-1:0] A_EN_SET = ADDR_W'(RI_EN_SET) << (2 + BANK_SEL_W);
  localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(RI_EN_CLR) << (2 + BANK_SEL_W);

  logic [REG_IDX_W-1:0] idx;
  logic                 clr_addr;
  assign idx      = addr_i[2+BANK_SEL_W +: REG_IDX_W];
  assign clr_addr = idx == REG_IDX_W'(RI_EN_CLR) || idx == REG_IDX_W'(RI_SW_CLR) ||
                    idx == REG_IDX_W'(RI_LAT_CLR);

  AST_EN_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_EN_SET) |=> ((en_all[BANK_W-1:0] & $past(wdata_i)) == $past(wdata_i))); // R2

  AST_EN_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_EN_CLR) |=> ((en_all[BANK_W-1:0] & $past(wdata_i)) == '0)); // R2

  AST_ROUTE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_all & fiq_all) == '0); // R4

  AST_LATCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(lat_all) & ~$past(lat_clr_all) & ~lat_all) == '0)); // R8

  AST_QUIET_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_all == '0) |=> (!irq_o && !fiq_o)); // R10

  AST_CLR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_addr |-> (rdata_o == '0)); // R12
endmodule

bind banked_intc intc_chk #(
  .NUM_SRC   (NUM_SRC),
  .BANK_SEL_W(BANK_SEL_W),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .irq_o      (irq_o),
  .fiq_o      (fiq_o),
  .en_all     (en_all),
  .lat_all    (lat_all),
  .lat_clr_all(lat_clr_all),
  .irq_all    (irq_all),
  .fiq_all    (fiq_all)
);

// File: tb/banked_intc_bench.sv
module banked_intc_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] src = '0;
  logic [63:0] src_cur = '0;
  logic        irq, fiq;
  int          total = 0;
  int          bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_intc u_banked_intc (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .src_i(src), .irq_o(irq), .fiq_o(fiq)
  );

  // cycle model built from the requirements
  logic [63:0] m_en, m_sw, m_sel, m_sense, m_dual, m_pol, m_lat, m_prev;
  logic        m_irq, m_fiq;

  function automatic logic [63:0] f_raw();
    logic [63:0] act = ~(src ^ m_pol);
    return m_sw | (m_sense & act) | (~m_sense & m_lat);
  endfunction

  function automatic logic [63:0] f_det();
    logic [63:0] act  = ~(src ^ m_pol);
    logic [63:0] pact = ~(m_prev ^ m_pol);
    return (m_dual & (src ^ m_prev)) | (~m_dual & act & ~pact);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    logic [63:0] v;
    case (a[7:3])
      5'd0:    v = f_raw() & m_en & ~m_sel;
      5'd1:    v = f_raw() & m_en & m_sel;
      5'd2:    v = f_raw();
      5'd3:    v = m_sel;
      5'd4:    v = m_en;
      5'd6:    v = m_sw;
      5'd8:    v = m_sense;
      5'd9:    v = m_dual;
      5'd10:   v = m_pol;
      5'd12:   v = m_lat;
      default: v = '0;
    endcase
    return a[2] ? v[63:32] : v[31:0];
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a[7:3])
      5'd0, 5'd1, 5'd2: return "R9";
      5'd3:             return "R4";
      5'd4:             return "R2";
      5'd6:             return "R3";
      5'd8, 5'd10:      return "R5";
      5'd9:             return "R7";
      5'd12:            return "R6";
      default:          return "R12";
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en <= '0; m_sw <= '0; m_sel <= '0; m_dual <= '0; m_lat <= '0; m_prev <= '0;
      m_sense <= '1; m_pol <= '1; m_irq <= 1'b0; m_fiq <= 1'b0;
    end else begin
      logic [63:0] wm, bm, clr;
      wm  = addr[2] ? {wdata, 32'h0} : {32'h0, wdata};
      bm  = addr[2] ? {32'hffffffff, 32'h0} : {32'h0, 32'hffffffff};
      clr = (we && addr[7:3] == 5'd11) ? wm : '0;
      m_irq  <= |(f_raw() & m_en & ~m_sel);
      m_fiq  <= |(f_raw() & m_en & m_sel);
      m_prev <= src;
      m_lat  <= (m_lat & ~clr) | (f_det() & ~m_sense);
      if (we) begin
        case (addr[7:3])
          5'd3:  m_sel   <= (m_sel & ~bm) | wm;
          5'd4:  m_en    <= m_en | wm;
          5'd5:  m_en    <= m_en & ~wm;
          5'd6:  m_sw    <= m_sw | wm;
          5'd7:  m_sw    <= m_sw & ~wm;
          5'd8:  m_sense <= (m_sense & ~bm) | wm;
          5'd9:  m_dual  <= (m_dual & ~bm) | wm;
          5'd10: m_pol   <= (m_pol & ~bm) | wm;
          default: ;
        endcase
      end
    end
  end

  task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h t=%0t", tag, addr, act, exp, $time);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    chk32("R10 irq_o", {31'h0, irq}, {31'h0, m_irq});
    chk32("R10 fiq_o", {31'h0, fiq}, {31'h0, m_fiq});
    we = w; addr = a; wdata = d; src = src_cur;
    #1;
    if (!w) chk32(tag_of(a), rdata, exp_rd(a));
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1'b1, a, d);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    step(1'b0, a, 32'h0);
    chk32(tag, rdata, exp);
  endtask

  task automatic idle();
    step(1'b0, 8'h70, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk32("R11 irq_o in reset", {31'h0, irq}, 32'h0);
    rst_ni = 1'b1;
    // R11 reset values
    rd(8'h40, 32'hffffffff, "R11 sense");
    rd(8'h54, 32'hffffffff, "R11 polarity high bank");
    rd(8'h20, 32'h0, "R11 enable");
    rd(8'h64, 32'h0, "R11 latch");
    chk32("R11 lines low", {30'h0, irq, fiq}, 32'h0);
    // R1 high bank level source 35
    src_cur[35] = 1'b1;
    wr(8'h24, 32'h8);
    rd(8'h14, 32'h8, "R1 raw high bank bit3");
    rd(8'h10, 32'h0, "R1 raw low bank untouched");
    rd(8'h04, 32'h8, "R9 irq view high");
    chk32("R10 irq_o follows view", {31'h0, irq}, 32'h1);
    // R4 reroute to fast line
    wr(8'h1c, 32'h8);
    rd(8'h0c, 32'h8, "R9 fiq view high");
    rd(8'h04, 32'h0, "R4 irq view empty");
    idle();
    chk32("R4 lines after reroute", {30'h0, irq, fiq}, 32'h1);
    // R5 active-low level
    wr(8'h54, 32'hfffffff7);
    rd(8'h14, 32'h0, "R5 active low, input high");
    src_cur[35] = 1'b0;
    rd(8'h14, 32'h8, "R5 active low, input low");
    wr(8'h2c, 32'hffffffff);
    wr(8'h54, 32'hffffffff);
    wr(8'h1c, 32'h0);
    // R6 rising edge on source 0
    wr(8'h40, 32'hfffffffe);
    wr(8'h20, 32'h1);
    src_cur[0] = 1'b1;
    idle();
    rd(8'h60, 32'h1, "R6 rising edge latched");
    rd(8'h10, 32'h1, "R9 raw from latch");
    src_cur[0] = 1'b0;
    idle();
    rd(8'h60, 32'h1, "R8 latch holds after input falls");
    wr(8'h58, 32'h1);
    rd(8'h60, 32'h0, "R8 latch cleared");
    // R8 edge and clear in the same cycle
    src_cur[0] = 1'b1;
    wr(8'h58, 32'h1);
    rd(8'h60, 32'h1, "R8 edge beats clear");
    wr(8'h58, 32'h1);
    rd(8'h60, 32'h0, "R8 clear with steady input");
    // R6 falling edge with polarity 0
    wr(8'h50, 32'hfffffffe);
    src_cur[0] = 1'b0;
    idle();
    rd(8'h60, 32'h1, "R6 falling edge latched");
    wr(8'h58, 32'h1);
    rd(8'h60, 32'h0, "R6 falling latch cleared");
    // R7 both edges
    wr(8'h48, 32'h1);
    src_cur[0] = 1'b1;
    idle();
    rd(8'h60, 32'h1, "R7 rise latched");
    wr(8'h58, 32'h1);
    rd(8'h60, 32'h0, "R7 cleared");
    src_cur[0] = 1'b0;
    idle();
    rd(8'h60, 32'h1, "R7 fall latched");
    wr(8'h58, 32'h1);
    // R8 clear on a level source
    src_cur[2] = 1'b1;
    wr(8'h58, 32'h4);
    rd(8'h10, 32'h4, "R8 level source unaffected by clear");
    src_cur[2] = 1'b0;
    // R3 soft trigger
    wr(8'h30, 32'h20);
    rd(8'h10, 32'h20, "R3 soft pending");
    rd(8'h30, 32'h20, "R3 soft readback");
    wr(8'h38, 32'h20);
    rd(8'h10, 32'h0, "R3 soft cleared");
    // R2 zero bits are no-ops
    wr(8'h20, 32'h0);
    rd(8'h20, 32'h1, "R2 set with zeros");
    wr(8'h28, 32'h0);
    rd(8'h20, 32'h1, "R2 clear with zeros");
    wr(8'h28, 32'h1);
    rd(8'h20, 32'h0, "R2 clear bit0");
    // R12 clear registers and holes
    rd(8'h28, 32'h0, "R12 enable clear reads 0");
    rd(8'h3c, 32'h0, "R12 soft clear reads 0");
    rd(8'h5c, 32'h0, "R12 latch clear reads 0");
    rd(8'h78, 32'h0, "R12 hole reads 0");
    // random phase, checked against the model
    for (int i = 0; i < 6000; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      logic        w;
      if ($urandom_range(0, 1) == 0)
        src_cur = src_cur ^ ({$urandom(), $urandom()} & {$urandom(), $urandom()} &
                             {$urandom(), $urandom()});
      w = ($urandom_range(0, 2) == 0);
      a = {5'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3))};
      d = ($urandom_range(0, 3) == 0) ? 32'hffffffff : $urandom();
      step(w, a, d);
    end
    step(1'b0, 8'h00, 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule